// File: doc/BRIEF.md
# Frame-Synced Serial Transmit Port

This block sends 16-bit words out one at a time over three lines: a bit clock, a frame-sync strobe and a serial data line. A producer hands it words over a valid/ready handshake. The block loads each word into a shift register and sends it most-significant bit first. A one-bit-period frame-sync pulse marks the start of each word.

The core clock runs at twice the bit rate, so one bit period takes two core cycles. In the first cycle the bit clock is high and in the second it is low. Data changes only at the rising edge of the bit clock, so a receiver that samples on the falling edge sees stable data.

A sequence of words starts after the port has been idle. The first word of a sequence is preceded by one extra bit-clock period with no frame sync. A word that is ready by the end of the current word follows directly, with no gap. When the port is idle, a configuration input decides whether the three lines are driven low or released to high impedance. The release is expressed through separate output-enable signals.

Top module: `sync_tx_port`

## Requirements
- R1: While reset is asserted and after reset, txClk, txSync and txData are 0 and inReady is 1.
- R2: While a sequence is active, every bit period lasts two core cycles: txClk is 1 in the first and 0 in the second.
- R3: The first word accepted while idle is preceded by exactly one bit period in which txClk pulses once and both txSync and txData are 0. This starts in the cycle after acceptance.
- R4: txSync is 1 for exactly the two core cycles of each word's first data bit period, and 0 at all other times.
- R5: Data is sent MSB first. Bit k of a word (k = 15 down to 0) is held on txData for both cycles of its bit period.
- R6: A word accepted in the second half of the last bit period starts in the very next cycle, with its sync period and no extra clock period.
- R7: If no word is accepted by the end of the last bit, the port goes idle the next cycle: txClk, txSync and txData stay 0. The next word again gets the extra period of R3.
- R8: inReady is 1 only while idle or in the second cycle of a word's last bit period. A word is taken only when inValid and inReady are both 1 at a clock edge, and inData is ignored otherwise.
- R9: While a sequence is active, all three enables are 1. While idle, each enable equals the inverse of cfgIdleHiZ: 0 drives the lines low and 1 releases them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgIdleHiZ | input | 1 | Idle behaviour: 0 drive low, 1 high impedance |
| inValid | input | 1 | Word offered |
| inData | input | 16 | Word to send |
| inReady | output | 1 | Port can take a word this cycle |
| txClk | output | 1 | Bit clock |
| txSync | output | 1 | Frame sync |
| txData | output | 1 | Serial data |
| txClkOe | output | 1 | Output enable for txClk |
| txSyncOe | output | 1 | Output enable for txSync |
| txDataOe | output | 1 | Output enable for txData |

## Verification
Several input patterns are used, and each tells a different fault apart:
- A lone word with mixed bits exposes bit-order and hold errors.
- Words offered continuously separate the back-to-back path from the idle-restart path, because only the idle path adds the extra clock period.
- A word offered just after the last-bit window shows whether the port really returned to idle and re-issued the leading period.
- All-zero, all-one and single-end-bit words, sent with both idle settings, check the sync position against the data.
- Changing the idle setting mid-word shows that it acts only while idle.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // take inData into the shift register
    logic shift;      // advance to the next bit
    logic run;        // sequence active, bit clock running
    logic clkHigh;    // first half of a bit period
    logic inShift;    // data bits on the line
    logic frameMark;  // first data bit period of a word
  } txStrobes_t;

endpackage

// File: rtl/sync_tx_ctrl.sv
module sync_tx_ctrl
  import sync_tx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output txStrobes_t strb
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  txState_t         state;
  logic             phase;
  logic [CNT_W-1:0] bitCnt;
  logic             accept;

  always_comb begin
    inReady = (state == ST_IDLE) ||
              ((state == ST_SHIFT) && (bitCnt == LAST_BIT) && phase);
    accept  = inValid && inReady;

    strb.load      = accept;
    strb.shift     = (state == ST_SHIFT) && phase && (bitCnt != LAST_BIT);
    strb.run       = (state != ST_IDLE);
    strb.clkHigh   = !phase;
    strb.inShift   = (state == ST_SHIFT);
    strb.frameMark = (state == ST_SHIFT) && (bitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= 1'b0;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          phase  <= 1'b0;
          bitCnt <= '0;
          if (accept) state <= ST_LEAD;
        end
        ST_LEAD: begin
          phase <= !phase;
          if (phase) begin
            state  <= ST_SHIFT;
            bitCnt <= '0;
          end
        end
        ST_SHIFT: begin
          phase <= !phase;
          if (phase) begin
            if (bitCnt == LAST_BIT) begin
              bitCnt <= '0;
              if (!accept) state <= ST_IDLE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sync_tx_dpath.sv
module sync_tx_dpath
  import sync_tx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strb,
  input  logic              cfgIdleHiZ,
  input  logic [DATA_W-1:0] inData,
  output logic              txClk,
  output logic              txSync,
  output logic              txData,
  output logic              txClkOe,
  output logic              txSyncOe,
  output logic              txDataOe
);

  logic [DATA_W-1:0] shReg;
  logic              driveOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strb.load) begin
      shReg <= inData;
    end else if (strb.shift) begin
      shReg <= {shReg[DATA_W-2:0], 1'b0};
    end
  end

  always_comb begin
    driveOn  = strb.run || !cfgIdleHiZ;
    txClk    = strb.run && strb.clkHigh;
    txSync   = strb.frameMark;
    txData   = strb.inShift && shReg[DATA_W-1];
    txClkOe  = driveOn;
    txSyncOe = driveOn;
    txDataOe = driveOn;
  end

endmodule

// File: rtl/sync_tx_port.sv
module sync_tx_port
  import sync_tx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgIdleHiZ,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              txClk,
  output logic              txSync,
  output logic              txData,
  output logic              txClkOe,
  output logic              txSyncOe,
  output logic              txDataOe
);

  txStrobes_t strb;

  sync_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .strb    (strb)
  );

  sync_tx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgIdleHiZ (cfgIdleHiZ),
    .inData     (inData),
    .txClk      (txClk),
    .txSync     (txSync),
    .txData     (txData),
    .txClkOe    (txClkOe),
    .txSyncOe   (txSyncOe),
    .txDataOe   (txDataOe)
  );

endmodule

// File: rtl/sync_tx_checker.sv
module sync_tx_checker (
  input logic clk,
  input logic rstN,
  input logic inReady,
  input logic txClk,
  input logic txSync,
  input logic txData,
  input logic txClkOe,
  input logic txSyncOe,
  input logic txDataOe
);

  a_r2_clk_single_high: assert property (@(posedge clk) disable iff (!rstN)
    txClk |=> !txClk);

  a_r4_sync_width: assert property (@(posedge clk) disable iff (!rstN)
    (txSync && $past(txSync)) |=> !txSync);

  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!txClk && $past(txClk)) |-> $stable(txData));

  a_r8_ready_low_half: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !txClk);

  a_r9_drive_when_active: assert property (@(posedge clk) disable iff (!rstN)
    txClk |-> (txClkOe && txSyncOe && txDataOe));

  a_r7_released_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !txClkOe |-> (!txSync && !txData && !txClk));

endmodule

bind sync_tx_port sync_tx_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inReady  (inReady),
  .txClk    (txClk),
  .txSync   (txSync),
  .txData   (txData),
  .txClkOe  (txClkOe),
  .txSyncOe (txSyncOe),
  .txDataOe (txDataOe)
);

// File: tb/sync_tx_port_tb.sv
module sync_tx_port_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rstN = 1'b0;
  logic         cfgIdleHiZ = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] inData = '0;
  logic inReady, txClk, txSync, txData, txClkOe, txSyncOe, txDataOe;

  sync_tx_port #(.DATA_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgIdleHiZ(cfgIdleHiZ),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .txClk(txClk), .txSync(txSync), .txData(txData),
    .txClkOe(txClkOe), .txSyncOe(txSyncOe), .txDataOe(txDataOe)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model: position in the current sequence, counted in core cycles
  bit           mBusy = 0;
  bit           mB2b  = 0;
  int           mPos  = 0;
  logic [W-1:0] mWord = '0;

  // {clk, sync, data, ready}
  function automatic logic [3:0] modelOut();
    int p, bitIdx, half;
    if (!mBusy) return 4'b0001;
    if (mPos < 2) return {(mPos == 0), 1'b0, 1'b0, 1'b0};
    p = mPos - 2;
    bitIdx = (p / 2) % W;
    half = p % 2;
    return {(half == 0), (bitIdx == 0), mWord[W-1-bitIdx],
            (bitIdx == W-1) && (half == 1)};
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [3:0] e;
    if (!rstN) begin
      mBusy = 0; mB2b = 0; mPos = 0;
    end else begin
      e = modelOut();
      if (!mBusy) begin
        if (inValid) begin mBusy = 1; mB2b = 0; mPos = 0; mWord = inData; end
      end else if (e[0]) begin
        if (inValid) begin mWord = inData; mPos = 2; mB2b = 1; end
        else begin mBusy = 0; mB2b = 0; end
      end else begin
        mPos++;
      end
    end
  end

  always @(negedge clk) begin
    logic [3:0] e;
    string tc, td;
    if (!done) begin
      e = modelOut();
      tc = !rstN ? "R1" : (!mBusy ? "R7" : (mPos < 2 ? "R3" : "R2"));
      td = !rstN ? "R1" : (mB2b ? "R6" : (mBusy && mPos < 2 ? "R3" : "R5"));
      chk(tc, "txClk", txClk, e[3]);
      chk(!rstN ? "R1" : "R4", "txSync", txSync, e[2]);
      chk(td, "txData", txData, e[1]);
      chk(!rstN ? "R1" : "R8", "inReady", inReady, e[0]);
      chk("R9", "txClkOe", txClkOe, mBusy || !cfgIdleHiZ);
      chk("R9", "txSyncOe", txSyncOe, mBusy || !cfgIdleHiZ);
      chk("R9", "txDataOe", txDataOe, mBusy || !cfgIdleHiZ);
    end
  end

  task automatic sendWord(logic [W-1:0] w);
    @(negedge clk);
    inValid = 1'b1;
    inData = w;
    forever begin
      if (inReady) begin @(posedge clk); break; end
      @(negedge clk);
    end
  endtask

  task automatic idleFor(int n);
    @(negedge clk);
    inValid = 1'b0;
    inData = 16'hDEAD; // R8: ignored while not valid
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idleFor(3);
    // lone word, idle drives low
    sendWord(16'hA5C3); idleFor(40);
    // back-to-back sequence (R6)
    sendWord(16'h1234); sendWord(16'h8001); sendWord(16'hFFFE); idleFor(40);
    // word arriving just after the last-bit window (R7)
    sendWord(16'h0F0F); idleFor(35); sendWord(16'hF0F0); idleFor(40);
    // released idle (R9)
    @(negedge clk); cfgIdleHiZ = 1'b1;
    sendWord(16'h0000); sendWord(16'hFFFF); idleFor(40);
    sendWord(16'h0001); idleFor(10);
    cfgIdleHiZ = 1'b0; idleFor(10);
    cfgIdleHiZ = 1'b1; idleFor(40);
    sendWord(16'h5555); idleFor(40);
    finishRun();
  end

endmodule